// File: doc/BRIEF.md
# Fixed-Point Audio Envelope Follower

This block tracks the level of one channel of signed 16-bit PCM audio. Every sample is rectified to an unsigned magnitude. The magnitude then feeds a first-order leaky integrator whose smoothing coefficient can be changed while audio is flowing. The result is a 16-bit unsigned envelope that a downstream gate, compressor, ducker or meter can use directly. A stereo design uses one instance per channel, and the channels share no state.

The pipeline has three registered stages: rectify, accumulate and output. It moves forward only on cycles where the advance enable is high, so latency is counted in advances, not clock cycles. A bypass control swaps the envelope for the raw input sample. The raw sample travels through a delay line of equal length, so switching bypass never changes the timing. The arithmetic is saturating, so no value can wrap.

Top module: `env_follower`

## Requirements
- R1: Stage one produces the magnitude |x| of the signed sample as a 16-bit unsigned value. An input of -32768 gives 32768 (0x8000) without saturation, so no magnitude is ever above 32768.
- R2: On a valid accumulator update the new envelope is env + ((alpha * (mag - env)) >>> 16). The difference is signed, the shift is an arithmetic floor, and the result is clamped to 0..65535. alpha is unsigned Q0.16, and the new envelope always lies between the old envelope and the magnitude.
- R3: A sample presented with valid high on one advance appears on env_o, with env_valid_o high, right after the third advance counted from that one. Valid follows the same three-advance path whether or not the sample was used.
- R4: While adv_i is low, no pipeline register changes. env_o and env_valid_o hold their values, and sample inputs presented on those cycles are ignored.
- R5: alpha_i is sampled on the advance that moves a sample into the accumulator (its second advance). A new alpha applies to the next update, with no flush of the pipeline.
- R6: While enable_i is low, the accumulator is cleared on every clock. The non-bypass output then loads zero (enable_i is sampled on the third advance), and valid still propagates. After enable_i returns high, tracking restarts from zero.
- R7: With bypass_i high at a sample's third advance, env_o carries that sample's raw 16-bit two's-complement bits. The latency is the same as on the envelope path.
- R8: Reset (rst_ni low) clears all valid flags, the accumulator and the output, so env_valid_o = 0 and env_o = 0.
- R9: An advance with smp_valid_i low moves an empty slot through the pipeline and leaves the accumulator unchanged. The output register holds its value for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Pipeline advance enable |
| smp_i | input | 16 | Signed PCM sample |
| smp_valid_i | input | 1 | Sample valid |
| alpha_i | input | 16 | Smoothing coefficient, unsigned Q0.16 |
| enable_i | input | 1 | Envelope tracking enable |
| bypass_i | input | 1 | Output raw delayed sample instead of envelope |
| env_o | output | 16 | Unsigned envelope or bypassed sample |
| env_valid_o | output | 1 | Output valid |

## Verification
Samples at the magnitude extremes (-32768, 32767, 0, -1) with alpha near one isolate the rectifier from the smoothing. A step up followed by silence at a small alpha separates attack from release and exposes rounding errors in the floor shift. A coefficient switch partway through a run shows which sample first uses the new alpha. Patterns with interleaved stalls, empty slots, disable and bypass tell a latency counted in clocks apart from one counted in advances, and show whether the accumulator is wrongly touched by slots that carry no sample.

// File: rtl/env_pkg.sv
package env_pkg;
  localparam int unsigned SMP_W   = 16;
  localparam int unsigned COEF_W  = 16;
  localparam int unsigned PIPE_N  = 3;
endpackage

// File: rtl/env_rectifier.sv
module env_rectifier #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [DW-1:0] smp_i,
  input  logic          vld_i,
  output logic [DW-1:0] mag_o,
  output logic          vld_o
);
  logic [DW-1:0] mag_d;

  // two's complement negate; most negative value maps to 2^(DW-1) unsigned
  assign mag_d = smp_i[DW-1] ? (~smp_i + {{(DW-1){1'b0}}, 1'b1}) : smp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_o <= '0;
      vld_o <= 1'b0;
    end else if (adv_i) begin
      mag_o <= mag_d;
      vld_o <= vld_i;
    end
  end

  // R1
  mag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag_o <= {1'b1, {(DW-1){1'b0}}});
endmodule

// File: rtl/env_integrator.sv
module env_integrator #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          en_i,
  input  logic [CW-1:0] alpha_i,
  input  logic [DW-1:0] mag_i,
  input  logic          vld_i,
  output logic [DW-1:0] env_o,
  output logic          vld_o
);
  localparam int unsigned DFW = DW + 2;
  localparam int unsigned PW  = DW + CW + 3;

  logic signed [DFW-1:0] diff;
  logic signed [PW-1:0]  prod;
  logic signed [PW-1:0]  step;
  logic signed [PW-1:0]  sum;
  logic [DW-1:0]         env_next;

  assign diff = $signed({2'b00, mag_i}) - $signed({2'b00, env_o});
  assign prod = $signed({{(PW-DFW){diff[DFW-1]}}, diff})
              * $signed({{(PW-CW){1'b0}}, alpha_i});
  assign step = prod >>> CW;
  assign sum  = step + $signed({{(PW-DW){1'b0}}, env_o});

  always_comb begin
    if (sum[PW-1])
      env_next = '0;
    else if (|sum[PW-2:DW])
      env_next = '1;
    else
      env_next = sum[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      env_o <= '0;
      vld_o <= 1'b0;
    end else begin
      if (!en_i)
        env_o <= '0;
      else if (adv_i && vld_i)
        env_o <= env_next;
      if (adv_i)
        vld_o <= vld_i;
    end
  end

  // R2
  env_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && vld_i) |=>
      ((env_o >= $past(env_o) || env_o >= $past(mag_i)) &&
       (env_o <= $past(env_o) || env_o <= $past(mag_i))));

  // R6
  env_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> env_o == '0);

  // R9
  empty_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(adv_i && vld_i)) |=> $stable(env_o));
endmodule

// File: rtl/env_delay.sv
module env_delay #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] tap [DEPTH+1];

  assign tap[0] = d_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        tap[g+1] <= '0;
      else if (adv_i)
        tap[g+1] <= tap[g];
    end
  end

  assign q_o = tap[DEPTH];
endmodule

// File: rtl/env_follower.sv
module env_follower
  import env_pkg::*;
#(
  parameter int unsigned DW = SMP_W,
  parameter int unsigned CW = COEF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [DW-1:0] smp_i,
  input  logic          smp_valid_i,
  input  logic [CW-1:0] alpha_i,
  input  logic          enable_i,
  input  logic          bypass_i,
  output logic [DW-1:0] env_o,
  output logic          env_valid_o
);
  localparam int unsigned RAW_DLY = PIPE_N - 1;

  logic [DW-1:0] mag_s1, env_s2, raw_s2;
  logic          vld_s1, vld_s2;

  env_rectifier #(.DW(DW)) u_rect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv_i),
    .smp_i (smp_i),
    .vld_i (smp_valid_i),
    .mag_o (mag_s1),
    .vld_o (vld_s1)
  );

  env_integrator #(.DW(DW), .CW(CW)) u_integ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv_i),
    .en_i   (enable_i),
    .alpha_i(alpha_i),
    .mag_i  (mag_s1),
    .vld_i  (vld_s1),
    .env_o  (env_s2),
    .vld_o  (vld_s2)
  );

  env_delay #(.W(DW), .DEPTH(RAW_DLY)) u_raw_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv_i),
    .d_i   (smp_i),
    .q_o   (raw_s2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      env_o       <= '0;
      env_valid_o <= 1'b0;
    end else if (adv_i) begin
      env_valid_o <= vld_s2;
      if (vld_s2)
        env_o <= bypass_i ? raw_s2 : (enable_i ? env_s2 : '0);
    end
  end

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(env_o) && $stable(env_valid_o)));

  // R3
  valid_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (env_valid_o == $past(vld_s2)));
endmodule

// File: tb/env_follower_test.sv
module env_follower_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 1'b0;
  logic [15:0] smp = '0;
  logic        smp_vld = 1'b0;
  logic [15:0] alpha = '0;
  logic        en = 1'b0;
  logic        byp = 1'b0;
  logic [15:0] env;
  logic        env_vld;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R8";
  bit mon_on = 1'b0;

  // reference pipeline state
  bit      m_v1, m_v2, m_v3;
  int      m_mag1, m_env, m_o3;
  logic [15:0] m_raw1, m_raw2;

  always #10 clk = ~clk;

  env_follower uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .adv_i      (adv),
    .smp_i      (smp),
    .smp_valid_i(smp_vld),
    .alpha_i    (alpha),
    .enable_i   (en),
    .bypass_i   (byp),
    .env_o      (env),
    .env_valid_o(env_vld)
  );

  function automatic int upd(int e, int m, int a);
    longint p;
    longint s;
    p = longint'(m - e) * longint'(a);
    s = longint'(e) + (p >>> 16);
    if (s < 0) s = 0;
    if (s > 65535) s = 65535;
    return int'(s);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v1 <= 0; m_v2 <= 0; m_v3 <= 0;
      m_mag1 <= 0; m_env <= 0; m_o3 <= 0;
      m_raw1 <= '0; m_raw2 <= '0;
    end else begin
      if (adv) begin
        m_v3 <= m_v2;
        if (m_v2) m_o3 <= byp ? int'(m_raw2) : (en ? m_env : 0);
        m_v2   <= m_v1;
        m_raw2 <= m_raw1;
        m_v1   <= smp_vld;
        m_raw1 <= smp;
        m_mag1 <= (smp[15] ? -int'($signed(smp)) : int'(smp));
      end
      if (!en) m_env <= 0;
      else if (adv && m_v1) m_env <= upd(m_env, m_mag1, int'(alpha));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      // R3 valid timing
      chk(env_vld == m_v3, {cur_req, "/R3 valid"}, int'(env_vld), int'(m_v3));
      if (m_v3)
        chk(int'(env) == m_o3, {cur_req, " data"}, int'(env), m_o3);
    end
  end

  task automatic push(input logic [15:0] s, input bit v);
    smp = s; smp_vld = v; adv = 1'b1;
    @(negedge clk);
    adv = 1'b0; smp_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      smp = 16'hA5A5; smp_vld = 1'b1; adv = 1'b0;
      @(negedge clk);
    end
    smp_vld = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) push(16'h0000, 1'b0);
  endtask

  task automatic t_reset();
    cur_req = "R8";
    chk(env_vld == 1'b0, "R8 valid at reset", int'(env_vld), 0);
    chk(env == 16'h0, "R8 env at reset", int'(env), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
  endtask

  task automatic t_rectify();
    cur_req = "R1";
    en = 1'b1; alpha = 16'hFFFF;
    push(16'd1000, 1);  push(-16'sd1000, 1); push(16'h8000, 1);
    push(16'h7FFF, 1);  push(16'h0000, 1);   push(16'hFFFF, 1);
    push(16'h8000, 1);  push(16'h8000, 1);   push(16'd12345, 1);
    drain();
  endtask

  task automatic t_attack_release();
    cur_req = "R2";
    alpha = 16'h2000;
    for (int i = 0; i < 12; i++) push(16'd20000, 1);
    for (int i = 0; i < 12; i++) push(16'd0, 1);
    alpha = 16'h0001;
    for (int i = 0; i < 4; i++) push(16'h8000, 1);
    drain();
  endtask

  task automatic t_alpha_change();
    cur_req = "R5";
    alpha = 16'h0800;
    for (int i = 0; i < 5; i++) push(-16'sd16000, 1);
    alpha = 16'hC000;
    for (int i = 0; i < 5; i++) push(-16'sd16000, 1);
    alpha = 16'h0000;
    for (int i = 0; i < 3; i++) push(16'd30000, 1);
    drain();
  endtask

  task automatic t_stall();
    cur_req = "R4";
    alpha = 16'h4000;
    for (int i = 0; i < 6; i++) begin
      push(16'(i * 3000 + 500), 1);
      idle(i % 3 + 1);
    end
    drain();
    idle(4);
  endtask

  task automatic t_gaps();
    cur_req = "R9";
    alpha = 16'h6000;
    for (int i = 0; i < 6; i++) begin
      push(16'd9000, 1);
      push(16'h7000, 0);
      push(16'h7000, 0);
    end
    drain();
  endtask

  task automatic t_disable();
    cur_req = "R6";
    alpha = 16'h8000;
    for (int i = 0; i < 3; i++) push(16'd20000, 1);
    drain();
    en = 1'b0;
    for (int i = 0; i < 5; i++) push(16'd25000, 1);
    drain();
    en = 1'b1;
    for (int i = 0; i < 3; i++) push(16'd25000, 1);
    drain();
  endtask

  task automatic t_bypass();
    cur_req = "R7";
    byp = 1'b1;
    push(16'h8000, 1); push(16'h1234, 1); push(16'hFFFE, 1); push(16'h7FFF, 1);
    drain();
    byp = 1'b0;
    push(16'd100, 1);
    drain();
  endtask

  task automatic t_mid_reset();
    cur_req = "R8";
    alpha = 16'hF000;
    for (int i = 0; i < 4; i++) push(16'd30000, 1);
    mon_on = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(env_vld == 1'b0, "R8 valid after reset", int'(env_vld), 0);
    chk(env == 16'h0, "R8 env after reset", int'(env), 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    push(16'd4000, 1);
    drain();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_rectify();
    t_attack_release();
    t_alpha_change();
    t_stall();
    t_gaps();
    t_disable();
    t_bypass();
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule